// File: doc/BRIEF.md
# Descriptor Ring DMA Channel

This block is a single DMA channel engine that walks a circular list of descriptors held in memory. Each descriptor takes eight bytes: a buffer pointer word at the lower address and a status word above it. Software sets the ring base address, the ring length and the direction, then raises the channel enable. The engine reads the status word of the descriptor at its current index. If the DMA side owns it, the engine reads the pointer and moves the data. It then writes the status back with ownership returned to the CPU and the completion flag set, and steps to the next index.

Data movement is modelled by beat counts. In transmit mode the engine sends one beat on the outbound stream for every `BEAT_BYTES` bytes of the descriptor length. In receive mode it accepts inbound beats up to one marked last, and it adds up the byte count of each beat. When the engine meets a descriptor that the CPU owns, it parks and flags the descriptor as unavailable. It stays there until software re-arms it.

Status word layout: bit 31 ownership (1 = DMA side), bit 30 completion, bit 29 start of packet, bit 28 end of packet, bits 27:23 byte offset, bit 22 receive length error, bits 15:0 length.

Top module: `ring_dma_chan`

## Requirements
- R1: After reset the engine issues no memory request and no stream beat. `desc_unavail` and `desc_done` are low and `ring_idx` is 0.
- R2: For each descriptor the engine first reads the status word at `cfg_base + 8*idx + 4`. Only if that word has bit 31 set does it read the pointer word at `cfg_base + 8*idx`.
- R3: A status word with bit 31 clear stops the engine without a transfer or a writeback. `desc_unavail` stays high and no memory request is made until a `rearm` pulse, after which the same index is read again.
- R4: In transmit mode (`cfg_rx` = 0) the engine sends ceil(len/`BEAT_BYTES`) beats, with len taken from status bits 15:0, so a zero length sends no beat. `st_out_sop` is high on the first beat only if bit 29 is set, and `st_out_eop` is high on the last beat only if bit 28 is set. `st_out_valid` holds until it is accepted.
- R5: During a transfer `xfer_addr` equals the pointer word plus the byte offset in status bits 27:23.
- R6: The status writeback goes out only after the last beat of the transfer. In transmit mode it is the read status with bit 31 cleared and bit 30 set. `desc_done` pulses for one cycle after each accepted writeback.
- R7: In receive mode (`cfg_rx` = 1) the writeback has bit 31 = 0 and bits 30, 29 and 28 = 1, keeps the byte offset, and carries in bits 15:0 the sum of `st_in_bytes` over the packet. Bit 22 and `desc_err` are set exactly when that sum is 1536 or more.
- R8: After each writeback the index advances, and it wraps to 0 when it reaches the ring length. A `cfg_ring_len` of 0 selects a ring of 25 descriptors.
- R9: Dropping `chan_en` lets the current descriptor finish. After that the engine makes no further request and keeps its index, and it resumes from that index when re-enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chan_en | input | 1 | Channel enable |
| cfg_rx | input | 1 | 1 = receive (stream to memory), 0 = transmit |
| cfg_base | input | AW | Ring base byte address |
| cfg_ring_len | input | IW | Descriptor count, 0 selects 25 |
| rearm | input | 1 | Pulse to leave the unavailable stop |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted this cycle, read data valid |
| mem_rdata | input | 32 | Read data |
| st_out_valid | output | 1 | Outbound beat valid |
| st_out_ready | input | 1 | Outbound beat accepted |
| st_out_sop | output | 1 | Outbound first beat of packet |
| st_out_eop | output | 1 | Outbound last beat of packet |
| st_in_valid | input | 1 | Inbound beat valid |
| st_in_ready | output | 1 | Engine accepts inbound beat |
| st_in_last | input | 1 | Inbound beat ends the packet |
| st_in_bytes | input | BW | Bytes carried by inbound beat |
| xfer_addr | output | AW | Buffer address of the current transfer |
| ring_idx | output | IW | Current descriptor index |
| desc_unavail | output | 1 | Stopped on a CPU-owned descriptor |
| desc_done | output | 1 | One-cycle pulse per descriptor retired |
| desc_err | output | 1 | Retired descriptor had a receive length error |

## Verification
The hardest condition to reach is the wrap from the last slot back to a slot that the engine has already retired. Reaching it needs a full lap of writebacks, and in the default ring that means 25 receive packets. The bench runs a lap of 25 receive packets and a shorter transmit lap, so the stop at index 0 comes from status words the engine wrote itself. It also drops the enable partway through a transmit burst, which checks that the engine finishes that descriptor and then goes quiet. Memory acknowledge and outbound ready both stall on fixed patterns, so the held-request paths are exercised throughout.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;

  localparam int unsigned OWN_BIT = 31;
  localparam int unsigned CPL_BIT = 30;
  localparam int unsigned SOP_BIT = 29;
  localparam int unsigned EOP_BIT = 28;
  localparam int unsigned OFF_LSB = 23;
  localparam int unsigned OFF_W   = 5;
  localparam int unsigned ERR_BIT = 22;
  localparam int unsigned LEN_W   = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_STAT,
    ST_RD_PTR,
    ST_XFER,
    ST_WB,
    ST_STALL
  } eng_state_t;

  // number of stream beats that carry len bytes
  function automatic logic [LEN_W:0] beat_count(input logic [LEN_W-1:0] len,
                                                input int unsigned bb);
    int unsigned t;
    t = (32'(len) + bb - 1) / bb;
    return (LEN_W+1)'(t);
  endfunction

  // transmit retire: hand back to CPU, mark complete, keep the rest
  function automatic logic [31:0] tx_retire(input logic [31:0] s);
    logic [31:0] r;
    r = s;
    r[OWN_BIT] = 1'b0;
    r[CPL_BIT] = 1'b1;
    return r;
  endfunction

  // receive retire: fresh word with measured length and error flag
  function automatic logic [31:0] rx_retire(input logic [31:0] s,
                                            input logic [LEN_W-1:0] len,
                                            input logic err);
    logic [31:0] r;
    r = '0;
    r[CPL_BIT] = 1'b1;
    r[SOP_BIT] = 1'b1;
    r[EOP_BIT] = 1'b1;
    r[OFF_LSB +: OFF_W] = s[OFF_LSB +: OFF_W];
    r[ERR_BIT] = err;
    r[LEN_W-1:0] = len;
    return r;
  endfunction

endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
  parameter int AW       = 32,
  parameter int IW       = 8,
  parameter int DEF_RING = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic [IW-1:0] ring_len,
  input  logic          advance,
  output logic [IW-1:0] idx,
  output logic [AW-1:0] ptr_addr,
  output logic [AW-1:0] stat_addr
);

  localparam logic [IW-1:0] DEF_LEN = IW'(DEF_RING);

  logic [IW-1:0] eff_len;
  logic [IW:0]   idx_inc;

  assign eff_len   = (ring_len == '0) ? DEF_LEN : ring_len;
  assign idx_inc   = {1'b0, idx} + 1'b1;
  assign ptr_addr  = base + (AW'(idx) << 3);
  assign stat_addr = ptr_addr + AW'(4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (advance) begin
      idx <= (idx_inc >= {1'b0, eff_len}) ? '0 : idx_inc[IW-1:0];
    end
  end

  assert_idx_in_ring_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idx < eff_len);

endmodule

// File: rtl/xfer_unit.sv
module xfer_unit
  import ring_dma_pkg::*;
#(
  parameter int BEAT_BYTES = 4,
  parameter int ERR_LEN    = 1536,
  parameter int BW         = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  input  logic             rx_mode,
  input  logic [LEN_W-1:0] tx_len,
  input  logic             tx_sop_f,
  input  logic             tx_eop_f,
  output logic             st_out_valid,
  input  logic             st_out_ready,
  output logic             st_out_sop,
  output logic             st_out_eop,
  input  logic             st_in_valid,
  output logic             st_in_ready,
  input  logic             st_in_last,
  input  logic [BW-1:0]    st_in_bytes,
  output logic             done,
  output logic [LEN_W-1:0] rx_len,
  output logic             rx_err
);

  localparam logic [LEN_W:0] LEN_MAX = {1'b0, {LEN_W{1'b1}}};

  logic [LEN_W:0] rem_q, total_q, acc_q, acc_sum;
  logic           got_last_q;
  logic           out_fire, in_fire;

  assign st_out_valid = active && !rx_mode && (rem_q != '0);
  assign st_out_sop   = st_out_valid && tx_sop_f && (rem_q == total_q);
  assign st_out_eop   = st_out_valid && tx_eop_f && (rem_q == (LEN_W+1)'(1));
  assign st_in_ready  = active && rx_mode && !got_last_q;
  assign out_fire     = st_out_valid && st_out_ready;
  assign in_fire      = st_in_valid && st_in_ready;
  assign acc_sum      = acc_q + (LEN_W+1)'(st_in_bytes);

  assign done   = active && (rx_mode ? got_last_q : (rem_q == '0));
  assign rx_len = acc_q[LEN_W-1:0];
  assign rx_err = acc_q >= (LEN_W+1)'(ERR_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q      <= '0;
      total_q    <= '0;
      acc_q      <= '0;
      got_last_q <= 1'b0;
    end else if (start) begin
      rem_q      <= beat_count(tx_len, BEAT_BYTES);
      total_q    <= beat_count(tx_len, BEAT_BYTES);
      acc_q      <= '0;
      got_last_q <= 1'b0;
    end else begin
      if (out_fire) rem_q <= rem_q - 1'b1;
      if (in_fire) begin
        acc_q <= (acc_sum > LEN_MAX) ? LEN_MAX : acc_sum;
        if (st_in_last) got_last_q <= 1'b1;
      end
    end
  end

  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st_out_valid && !st_out_ready |=> st_out_valid);

  assert_sop_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire |=> !st_out_sop);

endmodule

// File: rtl/status_pack.sv
module status_pack
  import ring_dma_pkg::*;
(
  input  logic [31:0]      stat,
  input  logic             rx_mode,
  input  logic [LEN_W-1:0] rx_len,
  input  logic             rx_err,
  output logic [31:0]      wb_word,
  output logic             wb_err
);

  assign wb_word = rx_mode ? rx_retire(stat, rx_len, rx_err) : tx_retire(stat);
  assign wb_err  = rx_mode && rx_err;

endmodule

// File: rtl/ring_dma_chan.sv
module ring_dma_chan
  import ring_dma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int IW         = 8,
  parameter int DEF_RING   = 25,
  parameter int BEAT_BYTES = 4,
  parameter int ERR_LEN    = 1536,
  localparam int BW        = $clog2(BEAT_BYTES) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          cfg_rx,
  input  logic [AW-1:0] cfg_base,
  input  logic [IW-1:0] cfg_ring_len,
  input  logic          rearm,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          st_out_valid,
  input  logic          st_out_ready,
  output logic          st_out_sop,
  output logic          st_out_eop,
  input  logic          st_in_valid,
  output logic          st_in_ready,
  input  logic          st_in_last,
  input  logic [BW-1:0] st_in_bytes,
  output logic [AW-1:0] xfer_addr,
  output logic [IW-1:0] ring_idx,
  output logic          desc_unavail,
  output logic          desc_done,
  output logic          desc_err
);

  eng_state_t       state_q;
  logic [31:0]      stat_q, ptr_q;
  logic             unavail_q, done_q, err_q;
  logic [AW-1:0]    ptr_addr, stat_addr;
  logic             xfer_start, xfer_done, retire;
  logic [LEN_W-1:0] rx_len;
  logic             rx_err, wb_err;
  logic [31:0]      wb_word;

  assign xfer_start = (state_q == ST_RD_PTR) && mem_ack;
  assign retire     = (state_q == ST_WB) && mem_ack;

  ring_ptr #(.AW(AW), .IW(IW), .DEF_RING(DEF_RING)) u_ring (
    .clk(clk), .rst_n(rst_n), .base(cfg_base), .ring_len(cfg_ring_len),
    .advance(retire), .idx(ring_idx), .ptr_addr(ptr_addr), .stat_addr(stat_addr)
  );

  xfer_unit #(.BEAT_BYTES(BEAT_BYTES), .ERR_LEN(ERR_LEN), .BW(BW)) u_xfer (
    .clk(clk), .rst_n(rst_n), .start(xfer_start), .active(state_q == ST_XFER),
    .rx_mode(cfg_rx), .tx_len(stat_q[LEN_W-1:0]),
    .tx_sop_f(stat_q[SOP_BIT]), .tx_eop_f(stat_q[EOP_BIT]),
    .st_out_valid(st_out_valid), .st_out_ready(st_out_ready),
    .st_out_sop(st_out_sop), .st_out_eop(st_out_eop),
    .st_in_valid(st_in_valid), .st_in_ready(st_in_ready),
    .st_in_last(st_in_last), .st_in_bytes(st_in_bytes),
    .done(xfer_done), .rx_len(rx_len), .rx_err(rx_err)
  );

  status_pack u_pack (
    .stat(stat_q), .rx_mode(cfg_rx), .rx_len(rx_len), .rx_err(rx_err),
    .wb_word(wb_word), .wb_err(wb_err)
  );

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = stat_addr;
    mem_wdata = wb_word;
    case (state_q)
      ST_RD_STAT: mem_req = 1'b1;
      ST_RD_PTR: begin
        mem_req  = 1'b1;
        mem_addr = ptr_addr;
      end
      ST_WB: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      stat_q    <= '0;
      ptr_q     <= '0;
      unavail_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (chan_en) state_q <= ST_RD_STAT;
        ST_RD_STAT: if (mem_ack) begin
          stat_q <= mem_rdata;
          if (mem_rdata[OWN_BIT]) begin
            state_q <= ST_RD_PTR;
          end else begin
            state_q   <= ST_STALL;
            unavail_q <= 1'b1;
          end
        end
        ST_RD_PTR: if (mem_ack) begin
          ptr_q   <= mem_rdata;
          state_q <= ST_XFER;
        end
        ST_XFER: if (xfer_done) state_q <= ST_WB;
        ST_WB: if (mem_ack) begin
          done_q  <= 1'b1;
          err_q   <= wb_err;
          state_q <= chan_en ? ST_RD_STAT : ST_IDLE;
        end
        ST_STALL: if (rearm) begin
          unavail_q <= 1'b0;
          state_q   <= chan_en ? ST_RD_STAT : ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign xfer_addr    = AW'(ptr_q) + AW'(stat_q[OFF_LSB +: OFF_W]);
  assign desc_unavail = unavail_q;
  assign desc_done    = done_q;
  assign desc_err     = err_q;

  assert_stall_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    desc_unavail |-> !mem_req && !st_out_valid && !st_in_ready);

  assert_wb_after_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req && mem_we) |-> $past(xfer_done));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |=> !desc_done);

  assert_done_follows_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |-> $past(mem_req && mem_we && mem_ack));

endmodule

// File: tb/ring_dma_chan_test.sv
`timescale 1ns/1ps
module ring_dma_chan_test;

  localparam int AW = 32;
  localparam int IW = 8;
  localparam int BW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chan_en = 1'b0;
  logic          cfg_rx = 1'b0;
  logic [AW-1:0] cfg_base = 32'h100;
  logic [IW-1:0] cfg_ring_len = 8'd4;
  logic          rearm = 1'b0;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          st_out_valid, st_out_ready, st_out_sop, st_out_eop;
  logic          st_in_valid = 1'b0, st_in_ready, st_in_last = 1'b0;
  logic [BW-1:0] st_in_bytes = '0;
  logic [AW-1:0] xfer_addr;
  logic [IW-1:0] ring_idx;
  logic          desc_unavail, desc_done, desc_err;

  always #4 clk = ~clk;

  ring_dma_chan uut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cfg_rx(cfg_rx),
    .cfg_base(cfg_base), .cfg_ring_len(cfg_ring_len), .rearm(rearm),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .st_out_valid(st_out_valid), .st_out_ready(st_out_ready),
    .st_out_sop(st_out_sop), .st_out_eop(st_out_eop),
    .st_in_valid(st_in_valid), .st_in_ready(st_in_ready),
    .st_in_last(st_in_last), .st_in_bytes(st_in_bytes),
    .xfer_addr(xfer_addr), .ring_idx(ring_idx), .desc_unavail(desc_unavail),
    .desc_done(desc_done), .desc_err(desc_err)
  );

  // memory model, single writer process
  bit [31:0]   mem_w [0:1023];
  int          cyc = 0;
  logic        bw_en = 1'b0;
  logic [31:0] bw_addr = '0, bw_data = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_we && mem_ack) mem_w[mem_addr[11:2]] <= mem_wdata;
    if (bw_en) mem_w[bw_addr[11:2]] <= bw_data;
  end

  assign mem_rdata    = mem_w[mem_addr[11:2]];
  assign mem_ack      = mem_req && ((cyc % 4) != 2);
  assign st_out_ready = (cyc % 3) != 1;

  // scoreboard
  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] data;
    logic [16:0] beats;
    logic        sop;
    logic        eop;
    logic [31:0] xaddr;
    logic        err;
    logic        rx;
  } item_t;

  item_t q[$];
  int    n_chk = 0, n_bad = 0;
  int    exp_idx = 0, ring_len_b = 4, wb_seen = 0, req_cycles = 0, beats_seen = 0;
  logic [31:0] base_b = 32'h100, last_stat = '0, first_xaddr = '0;
  logic  first_sop = 0, last_eop = 0, mid_sop = 0, pend_done = 0, pend_err = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) req_cycles++;
      if (pend_done) begin
        chk(desc_done === 1'b1, "R6 done pulse", desc_done, 1);
        chk(desc_err === pend_err, "R7 error flag", desc_err, pend_err);
        pend_done = 0;
      end else if (desc_done) begin
        chk(0, "R6 stray done", 1, 0);
      end
      if (st_out_valid && st_out_ready) begin
        if (beats_seen == 0) begin
          first_sop = st_out_sop;
          first_xaddr = xfer_addr;
        end else if (st_out_sop) mid_sop = 1;
        last_eop = st_out_eop;
        beats_seen++;
      end
      if (st_in_valid && st_in_ready) begin
        if (beats_seen == 0) first_xaddr = xfer_addr;
        beats_seen++;
      end
      if (mem_req && mem_ack && !mem_we) begin
        if (mem_addr[2]) begin
          chk(mem_addr == base_b + 32'(8 * exp_idx + 4), "R2 status read address",
              mem_addr, base_b + 32'(8 * exp_idx + 4));
          last_stat = mem_addr;
        end else begin
          chk(mem_addr == last_stat - 4, "R2 pointer read address", mem_addr, last_stat - 4);
        end
      end
      if (mem_req && mem_ack && mem_we) begin
        if (q.size() == 0) begin
          chk(0, "R6 unexpected writeback", mem_addr, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(mem_addr == it.addr, "R6 writeback address", mem_addr, it.addr);
          chk(mem_wdata == it.data, it.rx ? "R7 rx status word" : "R6 tx status word",
              mem_wdata, it.data);
          chk(beats_seen == int'(it.beats), "R4 beat count", beats_seen, it.beats);
          if (it.beats != 0) begin
            chk(first_xaddr == it.xaddr, "R5 buffer address", first_xaddr, it.xaddr);
            if (!it.rx) begin
              chk(first_sop == it.sop && !mid_sop, "R4 sop marking", first_sop, it.sop);
              chk(last_eop == it.eop, "R4 eop marking", last_eop, it.eop);
            end
          end
          pend_err = it.err;
        end
        exp_idx = (exp_idx + 1 >= ring_len_b) ? 0 : exp_idx + 1;
        wb_seen++;
        pend_done = 1;
        beats_seen = 0;
        mid_sop = 0;
      end
    end
  end

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bw_en = 1'b1; bw_addr = a; bw_data = d;
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  task automatic tx_slot(input int slot, input logic [31:0] ptr, input logic [15:0] len,
                         input logic [4:0] off, input bit sop, input bit eop, input bit own);
    logic [31:0] s;
    item_t it;
    s = {own, 1'b0, sop, eop, off, 7'b0, len};
    poke(base_b + 32'(8 * slot), ptr);
    poke(base_b + 32'(8 * slot + 4), s);
    if (own) begin
      it.addr  = base_b + 32'(8 * slot + 4);
      it.data  = {2'b01, s[29:0]};
      it.beats = 17'((32'(len) + 3) / 4);
      it.sop   = sop;
      it.eop   = eop;
      it.xaddr = ptr + 32'(off);
      it.err   = 1'b0;
      it.rx    = 1'b0;
      q.push_back(it);
    end
  endtask

  task automatic rx_slot(input int slot, input logic [31:0] ptr, input logic [4:0] off,
                         input int len, input int nbeats);
    item_t it;
    logic e;
    e = (len >= 1536);
    poke(base_b + 32'(8 * slot), ptr);
    poke(base_b + 32'(8 * slot + 4), {1'b1, 3'b000, off, 7'b0, 16'd1600});
    it.addr  = base_b + 32'(8 * slot + 4);
    it.data  = {4'b0111, off, e, 6'b0, 16'(len)};
    it.beats = 17'(nbeats);
    it.sop   = 1'b1;
    it.eop   = 1'b1;
    it.xaddr = ptr + 32'(off);
    it.err   = e;
    it.rx    = 1'b1;
    q.push_back(it);
  endtask

  task automatic rx_packet(input int nbeats, input int last_bytes);
    for (int b = 0; b < nbeats; b++) begin
      @(negedge clk);
      st_in_valid = 1'b1;
      st_in_last  = (b == nbeats - 1);
      st_in_bytes = (b == nbeats - 1) ? BW'(last_bytes) : BW'(4);
      #1;
      while (!st_in_ready) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    st_in_valid = 1'b0;
    st_in_last  = 1'b0;
  endtask

  task automatic pulse_rearm();
    @(negedge clk);
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int rq0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mem_req === 1'b0, "R1 no request", mem_req, 0);
    chk(st_out_valid === 1'b0, "R1 no beat", st_out_valid, 0);
    chk(desc_unavail === 1'b0 && desc_done === 1'b0, "R1 flags low",
        {desc_unavail, desc_done}, 0);
    chk(ring_idx == 0, "R1 index zero", ring_idx, 0);

    // transmit lap on a ring of 4
    tx_slot(0, 32'h1000, 16'd8, 5'd3, 1, 1, 1);
    tx_slot(1, 32'h2000, 16'd13, 5'd0, 1, 0, 1);
    tx_slot(2, 32'h3000, 16'd0, 5'd7, 0, 1, 1);
    tx_slot(3, 32'h0, 16'd4, 5'd0, 0, 0, 0);
    @(negedge clk);
    chan_en = 1'b1;
    wait (wb_seen == 1);
    @(negedge clk);
    while (!st_out_valid) @(negedge clk);
    chan_en = 1'b0;                       // R9 drop mid burst
    wait (wb_seen == 2);
    @(negedge clk);
    rq0 = req_cycles;
    repeat (12) @(negedge clk);
    chk(req_cycles == rq0, "R9 quiet after disable", req_cycles - rq0, 0);
    chk(ring_idx == 2, "R9 index retained", ring_idx, 2);
    chan_en = 1'b1;
    wait (desc_unavail);
    @(negedge clk);
    chk(ring_idx == 3, "R3 stop index", ring_idx, 3);
    chk(wb_seen == 3, "R3 no writeback on CPU-owned", wb_seen, 3);
    rq0 = req_cycles;
    repeat (10) @(negedge clk);
    chk(desc_unavail === 1'b1, "R3 unavailable held", desc_unavail, 1);
    chk(req_cycles == rq0, "R3 no request while stopped", req_cycles - rq0, 0);

    // hand slot 3 over, re-arm, expect wrap onto retired slot 0
    tx_slot(3, 32'h4000, 16'd4, 5'd1, 1, 1, 1);
    pulse_rearm();
    wait (wb_seen == 4);
    wait (desc_unavail);
    @(negedge clk);
    chk(ring_idx == 0, "R8 wrap at ring length", ring_idx, 0);
    chk(wb_seen == 4, "R8 stop at retired slot", wb_seen, 4);

    // leave stop with channel off
    chan_en = 1'b0;
    pulse_rearm();
    @(negedge clk);
    chk(desc_unavail === 1'b0, "R3 rearm clears flag", desc_unavail, 0);

    // receive lap on the default ring length
    cfg_rx = 1'b1;
    cfg_base = 32'h400;
    cfg_ring_len = '0;
    base_b = 32'h400;
    ring_len_b = 25;
    for (int i = 0; i < 25; i++) begin
      int ln, nb;
      if (i == 0) begin ln = 10; nb = 3; end
      else if (i == 1) begin ln = 1536; nb = 384; end
      else if (i == 2) begin ln = 1535; nb = 384; end
      else begin ln = (i % 4) + 1; nb = 1; end
      rx_slot(i, 32'h8000 + 32'(i * 32'h100), 5'(i), ln, nb);
    end
    @(negedge clk);
    chan_en = 1'b1;
    rx_packet(3, 2);
    rx_packet(384, 4);
    rx_packet(384, 3);
    for (int i = 3; i < 25; i++) rx_packet(1, (i % 4) + 1);
    wait (wb_seen == 29);
    wait (desc_unavail);
    @(negedge clk);
    chk(ring_idx == 0, "R8 default ring of 25 wraps", ring_idx, 0);
    chk(q.size() == 0, "R6 all descriptors retired", q.size(), 0);
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule